// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block manages 128 general-purpose pins arranged as four banks of 32. Software reaches it through a simple 32-bit register port with separate write and read strobes. Each pin has a direction bit. When the direction bit is 1 the pin drives the value of its output latch. Software changes that latch through a set register and a clear register, so single bits can be changed without a read-modify-write. Each pin can also store a two-bit alternate-function code; the block only holds this code and does not act on it.

Pin inputs pass through a two-flop synchronizer. The block then compares each synchronized input with its value one cycle earlier. For an input pin, a rising or falling change that has its enable bit set latches a sticky status bit. Software clears a status bit by writing 1 to it.

The status bits drive three interrupt lines:
- one line for pin 0,
- one line for pin 1,
- one line for the OR of all other status bits.

While the core is halted, a level change on any input pin in a fixed wake set produces a one-cycle wake pulse.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register reads zero and `pinOut`, `intPin0`, `intPin1`, `intOther`, `wakeReq` and `accErr` are low.
- R2: Each register kind has four word offsets, one per bank. The fourth bank sits apart from the other three, for example direction at 0x00C/0x010/0x014/0x10C. A value written to one bank's register reads back at that bank's offset only.
- R3: A pin-level read (offsets 0x000/0x004/0x008/0x100) returns the output latch for bits whose direction is 1 and the synchronized input for bits whose direction is 0.
- R4: A write to output-set (0x018/0x01C/0x020/0x118) ORs the written value into the latch, and reading output-set returns the last value written to it. A write to output-clear (0x024/0x028/0x02C/0x124) clears the latch bits written as 1, and reading output-clear returns the constant 0xC1EA0000.
- R5: `pinOut` equals the output latch ANDed with the direction register, bit for bit.
- R6: A status bit (offsets 0x048/0x04C/0x050/0x148) is set only when all of these hold:
  - the pin's direction is 0,
  - its synchronized input goes 0 to 1 with the rising enable (0x030/0x034/0x038/0x130) set, or goes 1 to 0 with the falling enable (0x03C/0x040/0x044/0x13C) set.
  
  A set status bit stays set until cleared.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new edge arrives in the same cycle as the clear, the status bit stays set.
- R8: `intPin0` is status bit 0 of bank 0, and `intPin1` is status bit 1 of bank 0. `intOther` is the OR of every other status bit in all four banks.
- R9: While `coreHalted` is 1, a level change on an input pin whose bit is set in the wake mask produces a one-cycle `wakeReq` pulse. The wake masks for banks 0 to 3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F. Nothing is produced while `coreHalted` is 0.
- R10: Pins numbered `PIN_COUNT` or above read as 0 in pin-level reads and never set status bits, whatever their input does.
- R11: An access at an unmapped or misaligned offset returns read data 0 and raises `accErr` for exactly one cycle.
- R12: The alternate-function registers store 32 bits each and read back what was written. Banks 0 to 3 use low/high offset pairs 0x054/0x058, 0x05C/0x060, 0x064/0x068 and 0x06C/0x070.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe; the register updates at this clock edge |
| regRdEn | input | 1 | Read strobe; `regRdata` is valid after this clock edge |
| regAddr | input | ADDR_W | Byte offset of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| accErr | output | 1 | One-cycle flag for an unmapped or misaligned access |
| pinIn | input | 128 | Asynchronous pin inputs |
| pinOut | output | 128 | Driven pin values (latch AND direction) |
| coreHalted | input | 1 | High while the core is halted |
| intPin0 | output | 1 | Interrupt for pin 0 status |
| intPin1 | output | 1 | Interrupt for pin 1 status |
| intOther | output | 1 | Interrupt for all other status bits |
| wakeReq | output | 1 | One-cycle wake pulse |

## Verification
The assertions assume that a read and a write are never strobed in the same cycle. They also assume that the offset 0xFFC is unmapped. The stimulus issues one access per cycle, with both strobes driven away from the clock edge. Every pin change is held for several cycles before the next access, so each edge passes the synchronizer before the result is read. The wake checks count one-cycle pulses on a falling clock edge. For that reason, a toggled wake pin always stays at its new level longer than one cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BANKS = 4;
  localparam int BANK_W = 32;
  localparam int TOTAL_PINS = BANKS * BANK_W;
  localparam int ALT_REGS = 2 * BANKS;

  // Kind order follows the offset stride of the first three banks: kind = wordIndex / 3
  typedef enum logic [3:0] {
    K_LEVEL, K_DIR, K_SET, K_CLR, K_RISE, K_FALL, K_STAT, K_ALT_LO, K_ALT_HI, K_NONE
  } regKindE;

  typedef struct packed {
    logic    wrEn;
    logic    rdEn;
    logic    badAcc;
    regKindE kind;
    logic [1:0] bank;
  } ctrlStrobeT;

  localparam logic [31:0] CLR_READ_VAL = 32'hC1EA_0000;
  localparam logic [TOTAL_PINS-1:0] WAKE_MASK =
    {32'h0012_007F, 32'hEC08_0000, 32'h0020_01FC, 32'h8003_FE1B};
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH = 128,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] stageR;

  always_ff @(posedge clk) begin
    if (!rstN) stageR[0] <= '0;
    else       stageR[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stageR[s] <= '0;
      else       stageR[s] <= stageR[s-1];
    end
  end

  assign syncOut = stageR[STAGES-1];
endmodule

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobeT        strobe
);
  localparam int LOW_END  = 'h054;
  localparam int ALT_LAST = 'h070;
  localparam int HI_BASE  = 'h100;
  localparam int HI_LAST  = 'h148;

  int      addrInt;
  int      wordIdx;
  regKindE kind;
  logic [1:0] bank;

  always_comb begin
    addrInt = int'(regAddr);
    wordIdx = 0;
    kind    = K_NONE;
    bank    = 2'd0;
    if (regAddr[1:0] == 2'b00) begin
      if (addrInt < LOW_END) begin
        wordIdx = addrInt >> 2;
        kind    = regKindE'(4'(wordIdx / 3));
        bank    = 2'(wordIdx % 3);
      end else if (addrInt <= ALT_LAST) begin
        wordIdx = (addrInt - LOW_END) >> 2;
        kind    = (wordIdx % 2 == 1) ? K_ALT_HI : K_ALT_LO;
        bank    = 2'(wordIdx / 2);
      end else if (addrInt >= HI_BASE && addrInt <= HI_LAST) begin
        wordIdx = (addrInt - HI_BASE) >> 2;
        if (wordIdx % 3 == 0) begin
          kind = regKindE'(4'(wordIdx / 3));
          bank = 2'd3;
        end
      end
    end
  end

  assign strobe.wrEn   = wrEn && (kind != K_NONE);
  assign strobe.rdEn   = rdEn && (kind != K_NONE);
  assign strobe.badAcc = (wrEn || rdEn) && (kind == K_NONE);
  assign strobe.kind   = kind;
  assign strobe.bank   = bank;
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 128
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobeT            strobe,
  input  logic [31:0]           wdata,
  input  logic [TOTAL_PINS-1:0] pinSync,
  input  logic                  coreHalted,
  output logic [31:0]           rdata,
  output logic                  accErr,
  output logic [TOTAL_PINS-1:0] pinOut,
  output logic                  intPin0,
  output logic                  intPin1,
  output logic                  intOther,
  output logic                  wakeReq
);
  localparam logic [TOTAL_PINS-1:0] PIN_VALID =
    (PIN_COUNT >= TOTAL_PINS) ? {TOTAL_PINS{1'b1}} : ((TOTAL_PINS'(1) << PIN_COUNT) - TOTAL_PINS'(1));

  logic [BANKS-1:0][BANK_W-1:0] dirR, outR, riseR, fallR, statR, setLastR;
  logic [ALT_REGS-1:0][BANK_W-1:0] altR;
  logic [BANKS-1:0][BANK_W-1:0] inView, prevR, clrMask, edgeHits;
  logic [31:0] readMux;
  logic [31:0] rdataR;
  logic        accErrR, wakeR;

  assign inView = pinSync & PIN_VALID;
  assign edgeHits = ~dirR & ((inView & ~prevR & riseR) | (~inView & prevR & fallR));

  always_comb begin
    clrMask = '0;
    if (strobe.wrEn && strobe.kind == K_STAT) clrMask[strobe.bank] = wdata;
  end

  always_comb begin
    case (strobe.kind)
      K_LEVEL:  readMux = (outR[strobe.bank] & dirR[strobe.bank]) |
                          (inView[strobe.bank] & ~dirR[strobe.bank]);
      K_DIR:    readMux = dirR[strobe.bank];
      K_SET:    readMux = setLastR[strobe.bank];
      K_CLR:    readMux = CLR_READ_VAL;
      K_RISE:   readMux = riseR[strobe.bank];
      K_FALL:   readMux = fallR[strobe.bank];
      K_STAT:   readMux = statR[strobe.bank];
      K_ALT_LO: readMux = altR[{strobe.bank, 1'b0}];
      K_ALT_HI: readMux = altR[{strobe.bank, 1'b1}];
      default:  readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirR <= '0; outR <= '0; riseR <= '0; fallR <= '0;
      statR <= '0; setLastR <= '0; altR <= '0; prevR <= '0;
      rdataR <= '0; accErrR <= 1'b0; wakeR <= 1'b0;
    end else begin
      prevR   <= inView;
      statR   <= (statR & ~clrMask) | edgeHits;
      wakeR   <= coreHalted && (|((inView ^ prevR) & ~dirR & WAKE_MASK));
      accErrR <= strobe.badAcc;
      if (strobe.rdEn)        rdataR <= readMux;
      else if (strobe.badAcc) rdataR <= '0;
      if (strobe.wrEn) begin
        case (strobe.kind)
          K_DIR:    dirR[strobe.bank]  <= wdata;
          K_SET: begin
            outR[strobe.bank]     <= outR[strobe.bank] | wdata;
            setLastR[strobe.bank] <= wdata;
          end
          K_CLR:    outR[strobe.bank]  <= outR[strobe.bank] & ~wdata;
          K_RISE:   riseR[strobe.bank] <= wdata;
          K_FALL:   fallR[strobe.bank] <= wdata;
          K_ALT_LO: altR[{strobe.bank, 1'b0}] <= wdata;
          K_ALT_HI: altR[{strobe.bank, 1'b1}] <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign rdata    = rdataR;
  assign accErr   = accErrR;
  assign wakeReq  = wakeR;
  assign pinOut   = outR & dirR;
  assign intPin0  = statR[0][0];
  assign intPin1  = statR[0][1];
  assign intOther = (|statR[0][BANK_W-1:2]) | (|statR[BANKS-1:1]);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 128,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [31:0]           regWdata,
  output logic [31:0]           regRdata,
  output logic                  accErr,
  input  logic [TOTAL_PINS-1:0] pinIn,
  output logic [TOTAL_PINS-1:0] pinOut,
  input  logic                  coreHalted,
  output logic                  intPin0,
  output logic                  intPin1,
  output logic                  intOther,
  output logic                  wakeReq
);
  ctrlStrobeT strobe;
  logic [TOTAL_PINS-1:0] pinSync;

  gpio_bank_sync #(.WIDTH(TOTAL_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(pinIn), .syncOut(pinSync)
  );

  gpio_bank_decode #(.ADDR_W(ADDR_W)) decode_i (
    .wrEn(regWrEn), .rdEn(regRdEn), .regAddr(regAddr), .strobe(strobe)
  );

  gpio_bank_dp #(.PIN_COUNT(PIN_COUNT)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(regWdata), .pinSync(pinSync),
    .coreHalted(coreHalted), .rdata(regRdata), .accErr(accErr), .pinOut(pinOut),
    .intPin0(intPin0), .intPin1(intPin1), .intOther(intOther), .wakeReq(wakeReq)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWrEn,
  input logic                  regRdEn,
  input logic [ADDR_W-1:0]     regAddr,
  input logic [31:0]           regWdata,
  input logic [31:0]           regRdata,
  input logic                  accErr,
  input logic [TOTAL_PINS-1:0] pinOut,
  input logic                  coreHalted,
  input logic                  intPin0,
  input logic                  wakeReq
);
  AST_INT0_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (intPin0 && !(regWrEn && regAddr == ADDR_W'('h048) && regWdata[0])) |=> intPin0); // R7

  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> $past(regWrEn || regRdEn)); // R11

  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'('hFFC)) |=> (accErr && regRdata == 32'h0)); // R11

  AST_CLR_READ_CONST: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'('h024)) |=> (regRdata == CLR_READ_VAL)); // R4

  AST_DIR_GATES_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'('h00C) && regWdata == 32'h0) |=> (pinOut[31:0] == 32'h0)); // R5

  AST_WAKE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $past(coreHalted)); // R9
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata), .accErr(accErr), .pinOut(pinOut),
  .coreHalted(coreHalted), .intPin0(intPin0), .wakeReq(wakeReq)
);

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 128;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic accErr;
  logic [NPINS-1:0] pinIn = '0;
  logic [NPINS-1:0] pinOut;
  logic coreHalted = 1'b0;
  logic intPin0, intPin1, intOther, wakeReq;

  int checks = 0;
  int fails = 0;
  int wakeCnt = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_ctrl #(.PIN_COUNT(100)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .accErr(accErr), .pinIn(pinIn),
    .pinOut(pinOut), .coreHalted(coreHalted), .intPin0(intPin0), .intPin1(intPin1),
    .intOther(intOther), .wakeReq(wakeReq)
  );

  always @(negedge clk) if (rstN && wakeReq) wakeCnt++;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG_CYCLES);
      summary();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    @(negedge clk); d = regRdata; e = accErr; regRdEn = 1'b0;
  endtask

  task automatic rdChk(string tag, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d; logic e;
    rd(a, d, e);
    chk(tag, d, exp);
  endtask

  task automatic setPin(int idx, logic v);
    @(negedge clk); pinIn[idx] = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 'h74; a += 4)
      if (!(a >= 'h24 && a < 'h30)) rdChk("R1 reg", 12'(a), 32'h0);
    for (int a = 'h100; a <= 'h148; a += 12)
      if (a != 'h124) rdChk("R1 bank3 reg", 12'(a), 32'h0);
    chk("R1 pinOut", 32'(pinOut != '0), 32'h0);
    chk("R1 ints", {29'h0, intPin0, intPin1, intOther}, 32'h0);
    chk("R1 wake/err", {30'h0, wakeReq, accErr}, 32'h0);
  endtask

  task automatic t_decode();
    wr(12'h00C, 32'h1111_1111); wr(12'h010, 32'h2222_2222);
    wr(12'h014, 32'h4444_4444); wr(12'h10C, 32'h8888_8888);
    rdChk("R2 dir bank0", 12'h00C, 32'h1111_1111);
    rdChk("R2 dir bank1", 12'h010, 32'h2222_2222);
    rdChk("R2 dir bank2", 12'h014, 32'h4444_4444);
    rdChk("R2 dir bank3", 12'h10C, 32'h8888_8888);
    wr(12'h00C, 0); wr(12'h010, 0); wr(12'h014, 0); wr(12'h10C, 0);
    rdChk("R2 dir bank3 cleared", 12'h10C, 32'h0);
  endtask

  task automatic t_output();
    wr(12'h010, 32'hFFFF_0000);
    wr(12'h01C, 32'h0F0F_0F0F);
    rdChk("R4 set readback", 12'h01C, 32'h0F0F_0F0F);
    chk("R5 pinOut after set", pinOut[63:32], 32'h0F0F_0000);
    wr(12'h028, 32'h0F00_0000);
    chk("R5 pinOut after clear", pinOut[63:32], 32'h000F_0000);
    rdChk("R4 clear read constant", 12'h028, 32'hC1EA_0000);
    @(negedge clk); pinIn[63:32] = 32'hFFFF_1234;
    repeat (5) @(negedge clk);
    rdChk("R3 level mix", 12'h004, 32'h000F_1234);
    wr(12'h010, 32'h0);
    chk("R5 pinOut dir off", pinOut[63:32], 32'h0);
    rdChk("R3 level all inputs", 12'h004, 32'hFFFF_1234);
    wr(12'h028, 32'hFFFF_FFFF);
    @(negedge clk); pinIn[63:32] = '0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_edges();
    wr(12'h030, 32'h0000_0023); wr(12'h03C, 32'h0000_0020);
    setPin(0, 1);
    rdChk("R6 rise pin0", 12'h048, 32'h1);
    chk("R8 int lines pin0", {29'h0, intPin0, intPin1, intOther}, 32'b100);
    setPin(5, 1);
    rdChk("R6 rise pin5", 12'h048, 32'h21);
    chk("R8 intOther pin5", {31'h0, intOther}, 32'h1);
    wr(12'h048, 32'h20);
    rdChk("R7 w1c bit5", 12'h048, 32'h1);
    chk("R8 intOther cleared", {31'h0, intOther}, 32'h0);
    setPin(5, 0);
    rdChk("R6 fall pin5", 12'h048, 32'h21);
    wr(12'h048, 32'h0);
    rdChk("R7 write zero keeps", 12'h048, 32'h21);
    wr(12'h048, 32'h21);
    rdChk("R7 clear all", 12'h048, 32'h0);
    chk("R8 int0 cleared", {31'h0, intPin0}, 32'h0);
    wr(12'h00C, 32'h2);
    setPin(1, 1);
    rdChk("R6 output pin ignored", 12'h048, 32'h0);
    chk("R8 int1 low for output", {31'h0, intPin1}, 32'h0);
    wr(12'h00C, 32'h0);
    setPin(1, 0);
    rdChk("R6 fall not enabled", 12'h048, 32'h0);
    setPin(1, 1);
    rdChk("R6 rise pin1", 12'h048, 32'h2);
    chk("R8 int1 high", {29'h0, intPin0, intPin1, intOther}, 32'b010);
    wr(12'h048, 32'h2);
    setPin(1, 0); setPin(0, 0);
    wr(12'h130, 32'hFFFF_FFFF);
    setPin(96, 1);
    rdChk("R6 bank3 rise", 12'h148, 32'h1);
    chk("R8 intOther bank3", {31'h0, intOther}, 32'h1);
    setPin(110, 1);
    rdChk("R10 beyond count no status", 12'h148, 32'h1);
    rdChk("R10 beyond count level", 12'h100, 32'h1);
    wr(12'h148, 32'hFFFF_FFFF);
    rdChk("R7 bank3 cleared", 12'h148, 32'h0);
    wr(12'h130, 32'h0);
    setPin(96, 0); setPin(110, 0);
    wr(12'h030, 32'h0); wr(12'h03C, 32'h0);
  endtask

  task automatic t_wake();
    int w0;
    @(negedge clk); coreHalted = 1'b1;
    w0 = wakeCnt;
    setPin(0, 1);
    chk("R9 wake on masked pin", 32'(wakeCnt - w0), 32'd1);
    w0 = wakeCnt;
    setPin(2, 1);
    chk("R9 no wake unmasked pin", 32'(wakeCnt - w0), 32'd0);
    @(negedge clk); coreHalted = 1'b0;
    w0 = wakeCnt;
    setPin(0, 0);
    chk("R9 no wake when running", 32'(wakeCnt - w0), 32'd0);
    setPin(2, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d; logic e;
    wr(12'h0FC, 32'hFFFF_FFFF);
    rd(12'h0FC, d, e);
    chk("R11 unmapped data", d, 32'h0);
    chk("R11 unmapped flag", {31'h0, e}, 32'h1);
    @(negedge clk);
    chk("R11 flag one cycle", {31'h0, accErr}, 32'h0);
    rd(12'h001, d, e);
    chk("R11 misaligned flag", {31'h0, e}, 32'h1);
    rd(12'h14C, d, e);
    chk("R11 gap in bank3 flag", {31'h0, e}, 32'h1);
    rd(12'h074, d, e);
    chk("R11 past alt data", d, 32'h0);
  endtask

  task automatic t_alt();
    wr(12'h054, 32'hFFFF_0000); wr(12'h06C, 32'hA5A5_0001); wr(12'h070, 32'h1234_5678);
    rdChk("R12 alt bank0 low", 12'h054, 32'hFFFF_0000);
    rdChk("R12 alt bank3 low", 12'h06C, 32'hA5A5_0001);
    rdChk("R12 alt bank3 high", 12'h070, 32'h1234_5678);
    rdChk("R12 alt bank0 high untouched", 12'h058, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_output();
    t_edges();
    t_wake();
    t_unmapped();
    t_alt();
    done = 1;
    summary();
  end
endmodule